// File: doc/BRIEF.md
# Bank-Interleaved Weight Address Sequencer

This block produces the burst address stream that feeds a matrix-vector kernel on a processing-in-memory channel. Each burst carries one packed vector of 16 half-precision values. The weight matrix is stored column-major over these packed vectors. The 16-element slice of one matrix row is followed directly by the same 16 columns of the next row. The bank field sits in the lowest address bits, so every burst moves to the next bank. As a result, eight neighbouring matrix rows are served by eight banks in parallel.

A start pulse captures the matrix row count, the matrix column count and a base address. The sequencer then walks through every burst of the matrix, producing one address per accepted cycle. Each address is split into channel, row, column and bank fields. Two register indices come with each address. The operand register index is read from the column bits of the address. The accumulator register index names the group of eight matrix rows being summed. A one-cycle done pulse marks the end of the matrix. An illegal shape raises an error flag and produces no addresses.

Top module: `pim_ag_top`

## Requirements
- R1: While reset is held and in the first cycle after it, valid, done and error are all low.
- R2: After a legal start, valid is high from the cycle after the start edge. It stays high until exactly rows*cols/16 bursts have been accepted, where a burst is accepted on a clock edge with valid and ready both high.
- R3: The bank output is bits [2:0] of the burst address. It increases by one (modulo 8) on every accepted burst, so any eight consecutive accepted bursts hit eight different banks.
- R4: Accepted burst number j (counted from 0) carries the linear address base+j, modulo 2^15. The fields of that address are: bank = bits [2:0], column = bits [7:3], row = bits [13:8], channel = bit 14. Burst j covers matrix row 8*g+(j mod 8), where g = j/(8*cols/16), and column chunk (j/8) mod (cols/16). The bank changes fastest, then the column chunk, then the row group.
- R5: The operand register index equals bits [2:0] of the column field of the address currently presented.
- R6: The accumulator register index equals the row group g of the current burst, modulo 8. This allows up to 64 matrix rows.
- R7: While valid is high and ready is low, valid stays high and every address field holds its value.
- R8: Done is high for exactly one cycle, the cycle after the edge that accepts the last burst. Valid is low in that cycle.
- R9: A start with a row count that is zero, above 64 or not a multiple of 8, or with a column count that is zero or not a multiple of 16, makes the error flag high from the next cycle. No address is produced. The flag stays high until the next start with a legal shape, which clears it.
- R10: A start pulse that arrives while a matrix is in progress is ignored. The sequence continues unchanged and the error flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; captures the shape and base |
| rows_i | input | 7 | Matrix row count |
| cols_i | input | 10 | Matrix column count in half-precision elements |
| base_i | input | 15 | Linear burst address of the first weight vector |
| ready_i | input | 1 | Consumer accepts the presented burst |
| valid_o | output | 1 | A burst address is presented |
| chan_o | output | 1 | Channel field |
| bank_o | output | 3 | Bank field |
| row_o | output | 6 | DRAM row field |
| col_o | output | 5 | Column field |
| opnd_o | output | 3 | Operand register index |
| acc_o | output | 3 | Accumulator register index |
| done_o | output | 1 | One-cycle end-of-matrix pulse |
| err_o | output | 1 | Illegal matrix shape flag |

## Verification
All outputs come from registers, so each is due a fixed number of cycles after its cause. Valid and the error flag appear one cycle after the start edge. The next address appears one cycle after each accepted burst. Done appears one cycle after the last accepted burst and is gone one cycle later. The bench drives inputs on the falling edge and reads outputs on the same falling edge, before the next rising edge. In that cycle it compares the address fields with base+j, decoded arithmetically, together with the expected row group. The sweep covers every legal row count from 8 to 64, several column counts and two base addresses, one of them unaligned and close to the top of the address space. It uses pseudo-random ready stalls, a start pulse injected mid-run and five illegal shapes.

// File: rtl/pim_ag_pkg.sv
package pim_ag_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ag_state_t;
endpackage

// File: rtl/pim_ag_cfg.sv
module pim_ag_cfg #(
   parameter int NROW_W   = 7,
   parameter int NCOL_W   = 10,
   parameter int BANK_W   = 3,
   parameter int VEC_W    = 4,
   parameter int MAX_ROWS = 64
) (
   input  logic [NROW_W-1:0] rows_i,
   input  logic [NCOL_W-1:0] cols_i,
   output logic              ok_o
);
   logic rows_ok;
   logic cols_ok;

   always_comb begin
      rows_ok = (rows_i != '0) && (rows_i[BANK_W-1:0] == '0) && (int'(rows_i) <= MAX_ROWS);
      cols_ok = (cols_i != '0) && (cols_i[VEC_W-1:0] == '0);
      ok_o    = rows_ok && cols_ok;
   end
endmodule

// File: rtl/pim_ag_seq.sv
module pim_ag_seq
   import pim_ag_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int NCH_W  = 6,
   parameter int NGRP_W = 4,
   parameter int K_W    = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [NCH_W-1:0]  nch_i,
   input  logic [NGRP_W-1:0] ngrp_i,
   input  logic              adv_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [K_W-1:0]    k_o,
   output logic [NGRP_W-1:0] grp_o
);
   ag_state_t         st_q;
   logic [BANK_W-1:0] bnk_q;
   logic [NCH_W-1:0]  chk_q;
   logic [NCH_W-1:0]  nch_q;
   logic [NGRP_W-1:0] grp_q;
   logic [NGRP_W-1:0] ngrp_q;
   logic [K_W-1:0]    k_q;
   logic              done_q;
   logic              last_bnk;
   logic              last_chk;
   logic              last_grp;

   always_comb begin
      last_bnk = &bnk_q;
      last_chk = (chk_q == nch_q - 1'b1);
      last_grp = (grp_q == ngrp_q - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bnk_q  <= '0;
         chk_q  <= '0;
         nch_q  <= '0;
         grp_q  <= '0;
         ngrp_q <= '0;
         k_q    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (go_i) begin
               st_q   <= ST_RUN;
               bnk_q  <= '0;
               chk_q  <= '0;
               grp_q  <= '0;
               k_q    <= '0;
               nch_q  <= nch_i;
               ngrp_q <= ngrp_i;
            end
         end else if (adv_i) begin
            k_q   <= k_q + 1'b1;
            bnk_q <= bnk_q + 1'b1;
            if (last_bnk) begin
               if (last_chk) begin
                  chk_q <= '0;
                  if (last_grp) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     grp_q <= grp_q + 1'b1;
                  end
               end else begin
                  chk_q <= chk_q + 1'b1;
               end
            end
         end
      end
   end

   assign busy_o = (st_q == ST_RUN);
   assign done_o = done_q;
   assign k_o    = k_q;
   assign grp_o  = grp_q;
endmodule

// File: rtl/pim_ag_decode.sv
module pim_ag_decode #(
   parameter int CH_W   = 1,
   parameter int ROW_W  = 6,
   parameter int COL_W  = 5,
   parameter int BANK_W = 3,
   parameter int OPND_W = 3
) (
   input  logic [CH_W+ROW_W+COL_W+BANK_W-1:0] lin_i,
   output logic [CH_W-1:0]                    chan_o,
   output logic [ROW_W-1:0]                   row_o,
   output logic [COL_W-1:0]                   col_o,
   output logic [BANK_W-1:0]                  bank_o,
   output logic [OPND_W-1:0]                  opnd_o
);
   localparam int COL_LSB = BANK_W;
   localparam int ROW_LSB = BANK_W + COL_W;
   localparam int CH_LSB  = BANK_W + COL_W + ROW_W;

   always_comb begin
      bank_o = lin_i[BANK_W-1:0];
      col_o  = lin_i[COL_LSB +: COL_W];
      row_o  = lin_i[ROW_LSB +: ROW_W];
      chan_o = lin_i[CH_LSB +: CH_W];
      opnd_o = col_o[OPND_W-1:0];
   end
endmodule

// File: rtl/pim_ag_top.sv
module pim_ag_top #(
   parameter int CH_W      = 1,
   parameter int ROW_W     = 6,
   parameter int COL_W     = 5,
   parameter int BANKS     = 8,
   parameter int VEC_ELEMS = 16,
   parameter int OPND_REGS = 8,
   parameter int ACC_REGS  = 8,
   parameter int NROW_W    = 7,
   parameter int NCOL_W    = 10,
   localparam int BANK_W   = $clog2(BANKS),
   localparam int VEC_W    = $clog2(VEC_ELEMS),
   localparam int OPND_W   = $clog2(OPND_REGS),
   localparam int ACC_W    = $clog2(ACC_REGS),
   localparam int ADDR_W   = CH_W + ROW_W + COL_W + BANK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NROW_W-1:0] rows_i,
   input  logic [NCOL_W-1:0] cols_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [CH_W-1:0]   chan_o,
   output logic [BANK_W-1:0] bank_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [COL_W-1:0]  col_o,
   output logic [OPND_W-1:0] opnd_o,
   output logic [ACC_W-1:0]  acc_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int NCH_W    = NCOL_W - VEC_W;
   localparam int NGRP_W   = NROW_W - BANK_W;
   localparam int MAX_ROWS = BANKS * ACC_REGS;

   generate
      if (BANKS != (1 << BANK_W)) begin : g_bad_banks
         $error("BANKS must be a power of two");
      end
      if (VEC_ELEMS != (1 << VEC_W)) begin : g_bad_vec
         $error("VEC_ELEMS must be a power of two");
      end
      if (OPND_W > COL_W) begin : g_bad_opnd
         $error("operand index wider than column field");
      end
      if (ACC_W > NGRP_W) begin : g_bad_acc
         $error("accumulator index wider than row-group count");
      end
      if (MAX_ROWS >= (1 << NROW_W)) begin : g_bad_rows
         $error("row count port too narrow for the row limit");
      end
      if (NCOL_W <= VEC_W) begin : g_bad_cols
         $error("column count port too narrow");
      end
   endgenerate

   logic              cfg_ok;
   logic              busy;
   logic              go;
   logic              adv;
   logic              err_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] k;
   logic [ADDR_W-1:0] lin;
   logic [NGRP_W-1:0] grp;

   pim_ag_cfg #(
      .NROW_W(NROW_W), .NCOL_W(NCOL_W), .BANK_W(BANK_W),
      .VEC_W(VEC_W), .MAX_ROWS(MAX_ROWS)
   ) u_cfg (
      .rows_i(rows_i), .cols_i(cols_i), .ok_o(cfg_ok)
   );

   assign go  = start_i && !busy && cfg_ok;
   assign adv = busy && ready_i;

   pim_ag_seq #(
      .BANK_W(BANK_W), .NCH_W(NCH_W), .NGRP_W(NGRP_W), .K_W(ADDR_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go),
      .nch_i(cols_i[NCOL_W-1:VEC_W]), .ngrp_i(rows_i[NROW_W-1:BANK_W]),
      .adv_i(adv), .busy_o(busy), .done_o(done_o), .k_o(k), .grp_o(grp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         base_q <= '0;
      end else if (start_i && !busy) begin
         err_q <= !cfg_ok;
         if (cfg_ok) base_q <= base_i;
      end
   end

   assign lin = base_q + k;

   pim_ag_decode #(
      .CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .OPND_W(OPND_W)
   ) u_dec (
      .lin_i(lin), .chan_o(chan_o), .row_o(row_o), .col_o(col_o),
      .bank_o(bank_o), .opnd_o(opnd_o)
   );

   assign valid_o = busy;
   assign acc_o   = grp[ACC_W-1:0];
   assign err_o   = err_q;
endmodule

// File: rtl/pim_ag_chk.sv
module pim_ag_chk #(
   parameter int CH_W   = 1,
   parameter int ROW_W  = 6,
   parameter int COL_W  = 5,
   parameter int BANK_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ready_i,
   input logic              valid_o,
   input logic [CH_W-1:0]   chan_o,
   input logic [BANK_W-1:0] bank_o,
   input logic [ROW_W-1:0]  row_o,
   input logic [COL_W-1:0]  col_o,
   input logic              done_o,
   input logic              err_o
);
   AST_FIRST_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(start_i)); // R2
   AST_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i) |=> (!valid_o || bank_o == $past(bank_o) + 1'b1)); // R3
   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> (valid_o && $stable({chan_o, row_o, col_o, bank_o}))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!valid_o && $past(valid_o && ready_i))); // R8
   AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !valid_o); // R9
endmodule

bind pim_ag_top pim_ag_chk #(
   .CH_W(CH_W), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
) u_pim_ag_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i),
   .valid_o(valid_o), .chan_o(chan_o), .bank_o(bank_o), .row_o(row_o),
   .col_o(col_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/test_pim_ag_top.sv
module test_pim_ag_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [6:0]  rows_i = '0;
   logic [9:0]  cols_i = '0;
   logic [14:0] base_i = '0;
   logic        ready_i = 1'b0;
   logic        valid_o;
   logic [0:0]  chan_o;
   logic [2:0]  bank_o;
   logic [5:0]  row_o;
   logic [4:0]  col_o;
   logic [2:0]  opnd_o;
   logic [2:0]  acc_o;
   logic        done_o;
   logic        err_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   pim_ag_top i_pim_ag_top (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rows_i(rows_i),
      .cols_i(cols_i), .base_i(base_i), .ready_i(ready_i), .valid_o(valid_o),
      .chan_o(chan_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
      .opnd_o(opnd_o), .acc_o(acc_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_job(input int rows, input int cols, input int base, input bit poke);
      int total;
      int nch;
      int j;
      bit stalled;
      bit poked;
      logic [14:0] held;
      total = rows * cols / 16;
      nch = cols / 16;
      j = 0;
      stalled = 0;
      poked = 0;
      held = '0;
      @(negedge clk);
      rows_i = 7'(rows); cols_i = 10'(cols); base_i = 15'(base);
      start_i = 1'b1; ready_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk(valid_o === 1'b1, "R2 valid after start", int'(valid_o), 1);
      chk(err_o === 1'b0, "R9 legal start clears error", int'(err_o), 0);
      while (j < total) begin
         logic [14:0] cur;
         logic [14:0] ea;
         cur = {chan_o, row_o, col_o, bank_o};
         chk(valid_o === 1'b1, "R2 valid during run", int'(valid_o), 1);
         if (stalled) chk(cur == held, "R7 hold on stall", int'(cur), int'(held));
         if (poke) chk(err_o === 1'b0, "R10 error untouched", int'(err_o), 0);
         if (poke && j == 3 && !poked) begin
            poked = 1;
            start_i = 1'b1;
            rows_i = 7'd5;
         end else begin
            start_i = 1'b0;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ready_i = lfsr[0] | lfsr[1];
         if (ready_i) begin
            ea = 15'(base + j);
            chk(bank_o == ea[2:0], "R3 bank", int'(bank_o), int'(ea[2:0]));
            chk(cur == ea, "R4 address", int'(cur), int'(ea));
            chk(opnd_o == ea[5:3], "R5 operand index", int'(opnd_o), int'(ea[5:3]));
            chk(int'(acc_o) == (j / (8 * nch)) % 8, "R6 accumulator index",
                int'(acc_o), (j / (8 * nch)) % 8);
            j++;
            stalled = 0;
         end else begin
            stalled = 1;
            held = cur;
         end
         @(negedge clk);
      end
      ready_i = 1'b0;
      start_i = 1'b0;
      chk(done_o === 1'b1, "R8 done after last", int'(done_o), 1);
      chk(valid_o === 1'b0, "R8 valid low with done", int'(valid_o), 0);
      @(negedge clk);
      chk(done_o === 1'b0, "R8 done single cycle", int'(done_o), 0);
      chk(valid_o === 1'b0, "R2 no extra burst", int'(valid_o), 0);
   endtask

   task automatic bad_cfg(input int rows, input int cols);
      @(negedge clk);
      rows_i = 7'(rows); cols_i = 10'(cols); base_i = 15'h0040;
      start_i = 1'b1; ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o === 1'b1, "R9 error raised", int'(err_o), 1);
      for (int i = 0; i < 3; i++) begin
         chk(valid_o === 1'b0, "R9 no address", int'(valid_o), 0);
         chk(done_o === 1'b0, "R9 no done", int'(done_o), 0);
         @(negedge clk);
      end
      chk(err_o === 1'b1, "R9 error held", int'(err_o), 1);
      ready_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(valid_o === 1'b0, "R1 valid in reset", int'(valid_o), 0);
      chk(done_o === 1'b0, "R1 done in reset", int'(done_o), 0);
      chk(err_o === 1'b0, "R1 error in reset", int'(err_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(valid_o === 1'b0, "R1 valid after reset", int'(valid_o), 0);
      chk(err_o === 1'b0, "R1 error after reset", int'(err_o), 0);

      run_job(8, 16, 32'h0000, 1'b1);
      bad_cfg(12, 32);
      bad_cfg(0, 32);
      bad_cfg(72, 32);
      bad_cfg(16, 24);
      bad_cfg(16, 0);
      for (int r = 8; r <= 64; r += 8) begin
         run_job(r, 16, 32'h0120, 1'b0);
         run_job(r, 32, 32'h7FFD, 1'b0);
         run_job(r, 48, 32'h0120, 1'b0);
         run_job(r, 128, 32'h7FFD, 1'b0);
      end
      run_job(64, 128, 32'h0005, 1'b1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule